// File: doc/BRIEF.md
# Collision Indicator Sequencer

This block drives the two-leg collision indication sent from a coax line transceiver back to the attached station. A square tone near 10 MHz is produced by dividing the system clock. It is gated onto the pair when any of three requests is present: a collision report from the line comparator, a jabber request from the transmit watchdog, and a heartbeat window. The heartbeat window confirms to the station that the indication path works.

The heartbeat is a delayed one-shot. When the transmit-valid input drops, a delay of `HB_DELAY` clock cycles runs, followed by a window of `HB_WIDTH` cycles. With a 40 MHz clock the defaults give 1.1 µs and 1.0 µs. A new transmission cancels a heartbeat that is pending or running, and a static enable input removes the heartbeat altogether.

The requests are ORed together, so requests that overlap give one unbroken tone. The gate opens and closes only on tone-period boundaries, so the pair never carries a shortened pulse. When the gate is closed, both legs sit high, which is a zero-differential idle rather than a driven low.

Top module: `cdi_seq`

## Requirements
- R1: After reset, and whenever no request has been active for a full tone period, cd_p and cd_n are both 1 (zero differential).
- R2: While the indication is active, cd_n is the complement of cd_p, and cd_p holds each level for exactly `TONE_HALF` clock cycles. The tone period is 2*`TONE_HALF` cycles (4 cycles, 10 MHz at 40 MHz by default).
- R3: While collision is held high, the tone appears within 2*`TONE_HALF` cycles and continues. After collision is released, the pair returns to idle within 2*`TONE_HALF` cycles.
- R4: jabber_req behaves the same way as collision.
- R5: When tx_valid falls (high on one rising edge, low on the next), the pair stays idle for `HB_DELAY` cycles. A heartbeat window of `HB_WIDTH` cycles then follows. The tone covers that window, with its edges rounded to tone-period boundaries.
- R6: While hb_enable is 0, a falling tx_valid produces no heartbeat tone.
- R7: tx_valid going high during the heartbeat delay or the heartbeat window cancels that heartbeat. Only a later fall of tx_valid starts a new one.
- R8: The tone always starts with a full high half-period on cd_p and ends after a full low half-period, so no pulse is shortened.
- R9: The three requests are ORed. Overlapping or handed-over requests give one tone with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | High while the station is transmitting |
| collision | input | 1 | Collision report from the line comparator |
| jabber_req | input | 1 | Jabber request from the transmit watchdog |
| hb_enable | input | 1 | 1 enables the heartbeat, 0 suppresses it |
| cd_p | output | 1 | Positive leg of the indication pair |
| cd_n | output | 1 | Negative leg of the indication pair |

## Verification
The assertions check these properties on every cycle:
- the idle level of both legs;
- the exact half-period length of every tone phase;
- that the tone starts high and ends low;
- that a request held for a full period always shows on the pair;
- that the heartbeat window is off whenever the heartbeat is disabled or a transmission is in progress.

The absolute timing of the heartbeat relative to the fall of tx_valid can only be seen in the bench's scenarios. The same holds for cancellation during the delay versus during the window, and for a seamless hand-over between overlapping requests. There, a scoreboard compares the pair's activity at computed cycles.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    typedef enum logic [1:0] {
        HB_IDLE = 2'd0,
        HB_WAIT = 2'd1,
        HB_WIN  = 2'd2
    } hb_state_e;

    // one bit per indication request
    typedef struct packed {
        logic col;
        logic jab;
        logic hb;
    } cdi_src_t;

    // divided tone: current level and last-cycle-of-period strobe
    typedef struct packed {
        logic hi;
        logic wrap;
    } tone_t;

    function automatic logic src_any(input cdi_src_t s);
        return s.col | s.jab | s.hb;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cdi_tone.sv
module cdi_tone
    import cdi_pkg::*;
#(
    parameter int unsigned TONE_HALF = 2
) (
    input  logic  clk,
    input  logic  rst,
    output tone_t tone
);
    localparam int unsigned PERIOD = 2 * TONE_HALF;
    localparam int unsigned CW     = cnt_bits(PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PERIOD - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tone.hi   = (cnt_q < CW'(TONE_HALF));
        tone.wrap = (cnt_q == CW'(PERIOD - 1));
    end
endmodule

// File: rtl/cdi_hb_timer.sv
module cdi_hb_timer
    import cdi_pkg::*;
#(
    parameter int unsigned HB_DELAY = 44,
    parameter int unsigned HB_WIDTH = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic hb_enable,
    output logic win
);
    localparam int unsigned MAXC = (HB_DELAY > HB_WIDTH) ? HB_DELAY : HB_WIDTH;
    localparam int unsigned CW   = cnt_bits(MAXC + 1);

    hb_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic          tx_d_q;
    logic          tx_end;

    assign tx_end = tx_d_q & ~tx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HB_IDLE;
            cnt_q  <= '0;
            tx_d_q <= 1'b0;
        end else begin
            tx_d_q <= tx_valid;
            if (!hb_enable || tx_valid) begin
                // disabled, or a new frame cancels any pending beat
                st_q  <= HB_IDLE;
                cnt_q <= '0;
            end else begin
                unique case (st_q)
                    HB_IDLE: begin
                        if (tx_end) begin
                            st_q  <= HB_WAIT;
                            cnt_q <= '0;
                        end
                    end
                    HB_WAIT: begin
                        if (cnt_q == CW'(HB_DELAY - 1)) begin
                            st_q  <= HB_WIN;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    HB_WIN: begin
                        if (cnt_q == CW'(HB_WIDTH - 1)) begin
                            st_q  <= HB_IDLE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        st_q  <= HB_IDLE;
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign win = (st_q == HB_WIN);
endmodule

// File: rtl/cdi_ind_gate.sv
module cdi_ind_gate
    import cdi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cdi_src_t src,
    input  tone_t    tone,
    output logic     cd_p,
    output logic     cd_n
);
    logic act_q;

    // gate changes only at the last cycle of a tone period
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else if (tone.wrap) begin
            act_q <= src_any(src);
        end
    end

    always_comb begin
        if (act_q) begin
            cd_p = tone.hi;
            cd_n = ~tone.hi;
        end else begin
            cd_p = 1'b1;
            cd_n = 1'b1;
        end
    end
endmodule

// File: rtl/cdi_seq.sv
module cdi_seq
    import cdi_pkg::*;
#(
    parameter int unsigned TONE_HALF = 2,
    parameter int unsigned HB_DELAY  = 44,
    parameter int unsigned HB_WIDTH  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic collision,
    input  logic jabber_req,
    input  logic hb_enable,
    output logic cd_p,
    output logic cd_n
);
    tone_t    tone;
    cdi_src_t src;
    logic     hb_win;

    cdi_tone #(.TONE_HALF(TONE_HALF)) u_tone (
        .clk  (clk),
        .rst  (rst),
        .tone (tone)
    );

    cdi_hb_timer #(.HB_DELAY(HB_DELAY), .HB_WIDTH(HB_WIDTH)) u_hb (
        .clk       (clk),
        .rst       (rst),
        .tx_valid  (tx_valid),
        .hb_enable (hb_enable),
        .win       (hb_win)
    );

    always_comb begin
        src.col = collision;
        src.jab = jabber_req;
        src.hb  = hb_win;
    end

    cdi_ind_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .src  (src),
        .tone (tone),
        .cd_p (cd_p),
        .cd_n (cd_n)
    );
endmodule

// File: rtl/cdi_seq_chk.sv
module cdi_seq_chk #(
    parameter int unsigned TONE_HALF = 2
) (
    input logic clk,
    input logic rst,
    input logic tx_valid,
    input logic collision,
    input logic jabber_req,
    input logic hb_enable,
    input logic hb_win,
    input logic cd_p,
    input logic cd_n
);
    localparam int unsigned PERIOD = 2 * TONE_HALF;

    logic       diff;
    logic       prev_diff_q;
    logic       prev_p_q;
    logic [7:0] run_q;
    logic [7:0] hold_q;
    logic       any_req;

    assign diff    = (cd_p != cd_n);
    assign any_req = collision | jabber_req | hb_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_diff_q <= 1'b0;
            prev_p_q    <= 1'b1;
            run_q       <= 8'd0;
            hold_q      <= 8'd0;
        end else begin
            prev_diff_q <= diff;
            prev_p_q    <= cd_p;
            run_q       <= (diff && prev_diff_q && cd_p == prev_p_q && run_q != 8'hff)
                           ? run_q + 8'd1 : 8'd1;
            hold_q      <= !any_req ? 8'd0 : (hold_q == 8'hff ? hold_q : hold_q + 8'd1);
        end
    end

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cd_p == cd_n) |-> cd_p);

    // R2
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        (diff && prev_diff_q && cd_p != prev_p_q) |-> (run_q == 8'(TONE_HALF)));

    // R8
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (diff && !prev_diff_q) |-> cd_p);

    // R8
    end_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!diff && prev_diff_q) |-> (!prev_p_q && run_q == 8'(TONE_HALF)));

    // R3 R4 R9
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q >= 8'(PERIOD)) |-> diff);

    // R6
    hb_off_chk: assert property (@(posedge clk) disable iff (rst)
        !hb_enable |=> !hb_win);

    // R7
    hb_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !hb_win);
endmodule

bind cdi_seq cdi_seq_chk #(.TONE_HALF(TONE_HALF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .collision  (collision),
    .jabber_req (jabber_req),
    .hb_enable  (hb_enable),
    .hb_win     (hb_win),
    .cd_p       (cd_p),
    .cd_n       (cd_n)
);

// File: tb/cdi_seq_bench.sv
module cdi_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TONE_HALF  = 2;
    localparam int PERIOD     = 2 * TONE_HALF;
    localparam int HB_DELAY   = 44;
    localparam int HB_WIDTH   = 40;

    typedef struct {
        int    cyc;
        bit    act;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst, tx_valid, collision, jabber_req, hb_enable;
    logic cd_p, cd_n;
    int   cyc;
    int   total = 0;
    int   bad   = 0;
    exp_t sb_q[$];

    cdi_seq #(.TONE_HALF(TONE_HALF), .HB_DELAY(HB_DELAY), .HB_WIDTH(HB_WIDTH)) u_cdi_seq (
        .clk        (clk),
        .rst        (rst),
        .tx_valid   (tx_valid),
        .collision  (collision),
        .jabber_req (jabber_req),
        .hb_enable  (hb_enable),
        .cd_p       (cd_p),
        .cd_n       (cd_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic push(input int c, input bit a, input string t);
        exp_t e;
        e.cyc = c; e.act = a; e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic note(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: scoreboard pops plus tone-shape tracking
    bit prev_diff = 0;
    bit prev_p    = 1;
    int run       = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit diff;
            diff = (cd_p != cd_n);
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                exp_t e;
                bit   ok;
                e  = sb_q.pop_front();
                ok = (e.cyc == cyc) && (e.act ? diff : (cd_p && cd_n));
                note(ok, $sformatf("%s cyc=%0d actual cd_p=%b cd_n=%b expected %s",
                                   e.tag, e.cyc, cd_p, cd_n, e.act ? "tone" : "idle 1/1"));
            end
            if (!diff && !cd_p)
                note(0, $sformatf("R1 idle low cyc=%0d actual cd_p=%b cd_n=%b expected 1/1",
                                  cyc, cd_p, cd_n));
            if (diff && !prev_diff) begin
                note(cd_p, $sformatf("R8 start cyc=%0d actual cd_p=%b expected 1", cyc, cd_p));
                run = 1;
            end else if (diff && prev_diff) begin
                if (cd_p == prev_p) begin
                    run++;
                end else begin
                    note(run == TONE_HALF, $sformatf("R2 half length cyc=%0d actual %0d expected %0d",
                                                     cyc, run, TONE_HALF));
                    run = 1;
                end
            end else if (!diff && prev_diff) begin
                note(!prev_p && run == TONE_HALF,
                     $sformatf("R8 end cyc=%0d actual last=%b len=%0d expected 0 len %0d",
                               cyc, prev_p, run, TONE_HALF));
            end
            prev_diff = diff;
            prev_p    = cd_p;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, c0, c1, w0, w1;
        rst = 1; tx_valid = 0; collision = 0; jabber_req = 0; hb_enable = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset idle
        push(1, 0, "R1"); push(3, 0, "R1");
        wait_to(5);

        // R3 collision
        c = cyc;
        push(c + PERIOD + 1, 1, "R3"); push(c + 12, 1, "R3"); push(c + 20 + PERIOD + 1, 0, "R3");
        collision = 1; wait_to(c + 20); collision = 0; wait_to(c + 40);

        // R4 jabber
        c = cyc;
        push(c + PERIOD + 1, 1, "R4"); push(c + 12, 1, "R4"); push(c + 20 + PERIOD + 1, 0, "R4");
        jabber_req = 1; wait_to(c + 20); jabber_req = 0; wait_to(c + 40);

        // R9 overlap and hand-over, tone must be unbroken
        c = cyc;
        for (int k = c + PERIOD + 1; k <= c + 24; k++) push(k, 1, "R9");
        push(c + 24 + PERIOD + 1, 0, "R9");
        collision = 1; wait_to(c + 8); jabber_req = 1; wait_to(c + 16);
        collision = 0; wait_to(c + 24); jabber_req = 0; wait_to(c + 45);

        // R5 heartbeat after end of frame
        c = cyc;
        push(c + 5, 0, "R5");
        tx_valid = 1; wait_to(c + 10);
        c0 = cyc; w0 = c0 + HB_DELAY + 1;
        push(c0 + 5, 0, "R5"); push(w0, 0, "R5"); push(w0 + PERIOD, 1, "R5");
        push(w0 + HB_WIDTH / 2, 1, "R5"); push(w0 + HB_WIDTH - 1, 1, "R5");
        push(w0 + HB_WIDTH + PERIOD, 0, "R5");
        tx_valid = 0; wait_to(w0 + HB_WIDTH + 20);

        // R6 heartbeat disabled
        hb_enable = 0;
        c = cyc; tx_valid = 1; wait_to(c + 10);
        c0 = cyc; w0 = c0 + HB_DELAY + 1;
        push(w0 + PERIOD, 0, "R6"); push(w0 + HB_WIDTH / 2, 0, "R6");
        tx_valid = 0; wait_to(w0 + HB_WIDTH + 20);
        hb_enable = 1; wait_to(cyc + 5);

        // R7 cancel during delay, later fall starts a fresh beat
        c = cyc; tx_valid = 1; wait_to(c + 6);
        c0 = cyc; tx_valid = 0; wait_to(c0 + 10);
        tx_valid = 1; wait_to(c0 + 16);
        c1 = cyc; w0 = c0 + HB_DELAY + 1; w1 = c1 + HB_DELAY + 1;
        push(w0 + PERIOD, 0, "R7"); push(w0 + 10, 0, "R7");
        push(w1 + PERIOD, 1, "R7"); push(w1 + HB_WIDTH - 1, 1, "R7");
        push(w1 + HB_WIDTH + PERIOD, 0, "R7");
        tx_valid = 0; wait_to(w1 + HB_WIDTH + 20);

        // R7 cancel during window
        c = cyc; tx_valid = 1; wait_to(c + 6);
        c0 = cyc; w0 = c0 + HB_DELAY + 1;
        push(w0 + PERIOD, 1, "R7");
        tx_valid = 0; wait_to(w0 + 8);
        push(w0 + 9 + PERIOD + 1, 0, "R7"); push(w0 + 25, 0, "R7");
        tx_valid = 1; wait_to(w0 + 30);
        tx_valid = 0; wait_to(cyc + HB_DELAY + HB_WIDTH + 20);

        while (sb_q.size() > 0) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule